// File: doc/BRIEF.md
# Mixed-Direction Port with Timer Override

This block is an 8-bit parallel port with a fixed role for each pin. Pins 0 to 2 only take input. Pins 4 to 6 only drive. Pins 3 and 7 can work either way, and each has a direction bit in a control register. A timer's output-compare channels can take a pin over. While they hold it, their value drives the pin and the pin is forced to output, whatever the data latch and the direction bit say. A general channel, channel 1, can claim any of pins 3 to 7. Pins 3 to 6 also each have a dedicated channel. Pin 7 has no dedicated channel.

Software uses a small register interface. The data register is at offset 0x00 and the control register is at offset 0x26. Pin 3 is shared between an input-capture use and an output-compare use, and control bit 2 chooses between them. Timer overrides act on pin 3 only while output compare is selected. The level on pin 7 is always brought out for a pulse accumulator, even while pin 7 drives.

Top module: `mixport_top`

## Requirements
- R1: After a synchronous reset, the control register reads 0x00, pins 3 and 7 are not driven (pin_oe[3] and pin_oe[7] are 0), and pins 4 to 6 drive 0 with output enable 1.
- R2: pin_oe[2:0] is always 0 and pin_out[2:0] is always 0. pin_oe[6:4] is always 1.
- R3: A write to offset 0x00 stores wdata bits 3 to 7 in the data latch. Its bits 0 to 2 have no effect: a later read of bits 0 to 2 of offset 0x00 returns pin_in[2:0].
- R4: Control bit 7 sets the direction of pin 7 and control bit 3 sets the direction of pin 3 (0 = input, 1 = output). A pin set to output drives its latch bit when no override claims it.
- R5: A read of offset 0x00 returns, for each bit, pin_out when pin_oe is 1 and pin_in when pin_oe is 0.
- R6: A write to offset 0x26 stores all 8 bits, and they read back unchanged. A read of any offset other than 0x00 or 0x26 returns 0, and a write to such an offset changes neither register.
- R7: Dedicated channels map ded_en[k] and ded_val[k] to pin 3+k, for k = 0 to 3. A dedicated channel that claims a pin sets pin_oe to 1 and pin_out to its value in the same cycle, ignoring the latch and the direction bit. When the claim ends, the pin returns to its latch and direction state with no register delay.
- R8: While control bit 2 is 0, neither ded_en[0] nor ch1_mask[0] affects pin 3.
- R9: Channel 1 maps ch1_mask[j] and ch1_data[j] to pin 3+j, for j = 0 to 4. It claims the pin in the same way as R7. When both channel 1 and a dedicated channel claim a pin, channel 1's value is driven.
- R10: pacc_in always equals pin_in[7], whatever the direction of pin 7 or any override on it.
- R11: A data write made while a pin is overridden is kept in the latch and appears on the pin once the override ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 6 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Values driven to the pins |
| pin_oe | output | 8 | Per-pin output enable |
| ch1_mask | input | 5 | Channel 1 claims on pins 3 to 7 |
| ch1_data | input | 5 | Channel 1 values for pins 3 to 7 |
| ded_en | input | 4 | Dedicated channel claims on pins 3 to 6 |
| ded_val | input | 4 | Dedicated channel values for pins 3 to 6 |
| pacc_in | output | 1 | Pin 7 level for the pulse accumulator |

## Verification
The bench builds the block with its default parameters: a 6-bit offset, the data register at 0x00 and the control register at 0x26. This width reaches the whole offset space, so random accesses hit both registers and also the unused offsets. Random stimulus changes the direction bits, the pin 3 select bit and both kinds of claim every cycle, so it reaches claim conflicts and the removal of an override. Directed cases fix the channel-1-over-dedicated conflict, the gating of pin 3 by control bit 2, and a write made while a pin is claimed.

// File: rtl/mixport_pkg.sv
package mixport_pkg;

    localparam int PORT_W = 8;
    localparam int OVR_LO = 3;              // lowest pin a timer may claim
    localparam int CH1_W  = PORT_W - OVR_LO; // channel 1 covers pins 3..7
    localparam int DED_W  = 4;              // dedicated channels cover pins 3..6
    localparam int CTRL_DIR7 = 7;
    localparam int CTRL_DIR3 = 3;
    localparam int CTRL_SEL3 = 2;           // 1 = pin 3 used for output compare

    typedef enum logic [1:0] {
        ROLE_IN    = 2'd0,
        ROLE_OUT   = 2'd1,
        ROLE_BIDIR = 2'd2
    } pin_role_e;

    typedef struct packed {
        logic en;
        logic val;
    } claim_t;

    function automatic pin_role_e pin_role(input int idx);
        if (idx < 3)       return ROLE_IN;
        else if (idx == 3) return ROLE_BIDIR;
        else if (idx < 7)  return ROLE_OUT;
        else               return ROLE_BIDIR;
    endfunction

    // channel 1 has priority over a dedicated channel
    function automatic claim_t merge_claim(input claim_t gen, input claim_t ded);
        claim_t r;
        r.en  = gen.en | ded.en;
        r.val = gen.en ? gen.val : ded.val;
        return r;
    endfunction

endpackage

// File: rtl/mixport_regs.sv
module mixport_regs
    import mixport_pkg::*;
#(
    parameter int              ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'h00,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    input  logic [PORT_W-1:0] pin_view,
    output logic [PORT_W-1:0] bus_rdata,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] ctrl_q
);

    logic wr_data, wr_ctrl;
    assign wr_data = bus_sel && bus_wr && (bus_addr == DATA_OFS);
    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == CTRL_OFS);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata;
    end

    for (genvar i = 0; i < PORT_W; i++) begin : g_lat
        if (pin_role(i) == ROLE_IN) begin : g_none
            assign latch_q[i] = 1'b0;
        end else begin : g_store
            logic q;
            always_ff @(posedge clk) begin
                if (rst)          q <= 1'b0;
                else if (wr_data) q <= bus_wdata[i];
            end
            assign latch_q[i] = q;
        end
    end

    always_comb begin
        if (bus_addr == DATA_OFS)      bus_rdata = pin_view;
        else if (bus_addr == CTRL_OFS) bus_rdata = ctrl_q;
        else                           bus_rdata = '0;
    end

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == CTRL_OFS) |=> ctrl_q == $past(bus_wdata)); // R6

    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == DATA_OFS) |=> latch_q[7:3] == $past(bus_wdata[7:3])); // R3

endmodule

// File: rtl/mixport_pinmux.sv
module mixport_pinmux
    import mixport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] ctrl_q,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [CH1_W-1:0]  ch1_mask,
    input  logic [CH1_W-1:0]  ch1_data,
    input  logic [DED_W-1:0]  ded_en,
    input  logic [DED_W-1:0]  ded_val,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_view
);

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        if (pin_role(i) == ROLE_IN) begin : g_in
            assign pin_out[i] = 1'b0;
            assign pin_oe[i]  = 1'b0;
        end else begin : g_drv
            logic   gate;
            logic   dir;
            claim_t gen_c, ded_c, win_c;
            if (i == 3) begin : g_p3
                assign gate = ctrl_q[CTRL_SEL3];
                assign dir  = ctrl_q[CTRL_DIR3];
            end else if (i == 7) begin : g_p7
                assign gate = 1'b1;
                assign dir  = ctrl_q[CTRL_DIR7];
            end else begin : g_po
                assign gate = 1'b1;
                assign dir  = 1'b1;
            end
            assign gen_c.en  = gate & ch1_mask[i-OVR_LO];
            assign gen_c.val = ch1_data[i-OVR_LO];
            if (i - OVR_LO < DED_W) begin : g_ded
                assign ded_c.en  = gate & ded_en[i-OVR_LO];
                assign ded_c.val = ded_val[i-OVR_LO];
            end else begin : g_noded
                assign ded_c = '0;
            end
            assign win_c      = merge_claim(gen_c, ded_c);
            assign pin_out[i] = win_c.en ? win_c.val : latch_q[i];
            assign pin_oe[i]  = win_c.en | dir;
        end
        assign pin_view[i] = pin_oe[i] ? pin_out[i] : pin_in[i];
    end

    AST_CH1_WINS: assert property (@(posedge clk) disable iff (rst)
        ch1_mask[2] |-> (pin_oe[5] && pin_out[5] == ch1_data[2])); // R9

    AST_DED_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (ded_en[2] && !ch1_mask[2]) |-> (pin_out[5] == ded_val[2])); // R7

    AST_P3_GATED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[CTRL_SEL3] && !ctrl_q[CTRL_DIR3]) |-> !pin_oe[3]); // R8

endmodule

// File: rtl/mixport_top.sv
module mixport_top
    import mixport_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'h00,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    input  logic [CH1_W-1:0]  ch1_mask,
    input  logic [CH1_W-1:0]  ch1_data,
    input  logic [DED_W-1:0]  ded_en,
    input  logic [DED_W-1:0]  ded_val,
    output logic              pacc_in
);

    logic [PORT_W-1:0] latch_q, ctrl_q, pin_view;

    mixport_regs #(.ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS)) u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_view(pin_view),
        .bus_rdata(bus_rdata), .latch_q(latch_q), .ctrl_q(ctrl_q)
    );

    mixport_pinmux u_pinmux (
        .clk(clk), .rst(rst), .latch_q(latch_q), .ctrl_q(ctrl_q), .pin_in(pin_in),
        .ch1_mask(ch1_mask), .ch1_data(ch1_data), .ded_en(ded_en), .ded_val(ded_val),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_view(pin_view)
    );

    assign pacc_in = pin_in[7];

endmodule

// File: tb/mixport_top_bench.sv
module mixport_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 0, bus_wr = 0;
    logic [5:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata, pin_in = 0, pin_out, pin_oe;
    logic [4:0] ch1_mask = 0, ch1_data = 0;
    logic [3:0] ded_en = 0, ded_val = 0;
    logic       pacc_in;

    int n_chk = 0, n_bad = 0;
    logic [7:0] m_lat = 0, m_ctrl = 0;

    always #4 clk = ~clk;

    mixport_top u_mixport_top (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .ch1_mask(ch1_mask), .ch1_data(ch1_data), .ded_en(ded_en),
        .ded_val(ded_val), .pacc_in(pacc_in)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    function automatic logic [1:0] exp_pin(input int i); // {oe, out}
        logic gate, dir, c1, cd;
        if (i < 3) return 2'b00;
        gate = (i != 3) || m_ctrl[2];
        dir  = (i == 3) ? m_ctrl[3] : (i == 7) ? m_ctrl[7] : 1'b1;
        c1   = gate && ch1_mask[i-3];
        cd   = gate && (i < 7) && ded_en[(i-3) % 4];
        if (c1)      return {1'b1, ch1_data[i-3]};
        else if (cd) return {1'b1, ded_val[(i-3) % 4]};
        else         return {dir, m_lat[i]};
    endfunction

    function automatic logic [7:0] exp_oe();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = exp_pin(i)[1];
        return r;
    endfunction

    function automatic logic [7:0] exp_out();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = exp_pin(i)[0];
        return r;
    endfunction

    function automatic logic [7:0] exp_rd();
        logic [7:0] oe, o;
        oe = exp_oe(); o = exp_out();
        if (bus_addr == 6'h00)      return (oe & o) | (~oe & pin_in);
        else if (bus_addr == 6'h26) return m_ctrl;
        else                        return 8'h00;
    endfunction

    task automatic check_all(input string tag);
        check({tag, " pin_oe"}, pin_oe, exp_oe());
        check({tag, " pin_out"}, pin_out, exp_out());
        check({tag, " rdata"}, bus_rdata, exp_rd());
        check({tag, " pacc_in R10"}, {7'd0, pacc_in}, {7'd0, pin_in[7]});
    endtask

    // inputs are already set; check mid-cycle, then commit at the edge
    task automatic cycle(input string tag);
        #2;
        check_all(tag);
        @(posedge clk);
        if (rst) begin
            m_lat = 0; m_ctrl = 0;
        end else if (bus_sel && bus_wr) begin
            if (bus_addr == 6'h00) m_lat = bus_wdata & 8'hF8;
            else if (bus_addr == 6'h26) m_ctrl = bus_wdata;
        end
        @(negedge clk);
    endtask

    task automatic bus(input logic wr, input logic [5:0] a, input logic [7:0] d);
        bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0311));
        @(negedge clk);
        pin_in = 8'hA5;
        cycle("reset R1");
        cycle("reset R1");
        rst = 0;
        // R1: control reads 0 after reset, bidir pins undriven
        bus(0, 6'h26, 0);
        #2;
        check("R1 ctrl", bus_rdata, 8'h00);
        check("R1 oe", pin_oe, 8'h70);
        check("R1 out", pin_out & 8'h70, 8'h00);
        @(negedge clk);
        // R3: write ignores bits 0..2; R2 fixed roles
        bus(1, 6'h00, 8'hFF); pin_in = 8'h02;
        cycle("R3 write");
        bus(0, 6'h00, 0);
        #2;
        check("R3 low bits read pin", bus_rdata & 8'h07, 8'h02);
        check("R2 oe roles", pin_oe, 8'h70);
        @(negedge clk);
        // R4: set both directions to output
        bus(1, 6'h26, 8'h88);
        cycle("R4 dir write");
        bus(0, 6'h00, 0); pin_in = 8'h00;
        #2;
        check("R4 oe", pin_oe, 8'hF8);
        check("R5 read driven", bus_rdata, 8'hF8);
        @(negedge clk);
        // R6: unused offset write is dropped
        bus(1, 6'h11, 8'h00);
        cycle("R6 bad offset write");
        bus(0, 6'h11, 0);
        #2; check("R6 bad offset read", bus_rdata, 8'h00);
        bus(0, 6'h26, 0);
        #2; check("R6 ctrl kept", bus_rdata, 8'h88);
        @(negedge clk);
        // R9: conflict on pin 5, channel 1 drives 0, dedicated drives 1
        ch1_mask = 5'b00100; ch1_data = 5'b00000; ded_en = 4'b0100; ded_val = 4'b0100;
        #2; check("R9 ch1 wins", {7'd0, pin_out[5]}, 8'h00);
        // R7: dedicated alone
        ch1_mask = 0;
        #2; check("R7 ded claim", {7'd0, pin_out[5]}, 8'h01);
        // R8: pin 3 claims ignored with control bit 2 = 0, dir3 = 0
        @(negedge clk);
        bus(1, 6'h26, 8'h00);
        cycle("R8 setup");
        ch1_mask = 5'b00001; ch1_data = 0; ded_en = 4'b0001; ded_val = 4'b0001;
        bus(0, 6'h00, 0);
        #2; check("R8 pin3 undriven", {7'd0, pin_oe[3]}, 8'h00);
        @(negedge clk);
        // R11: write while pin 4 claimed, then release
        ch1_mask = 5'b00010; ch1_data = 5'b00000; ded_en = 0;
        bus(1, 6'h00, 8'h10);
        cycle("R11 write under claim");
        bus(0, 6'h00, 0);
        #2; check("R11 claimed", {7'd0, pin_out[4]}, 8'h00);
        ch1_mask = 0;
        #2; check("R11 released", {7'd0, pin_out[4]}, 8'h01);
        @(negedge clk);
        // random phase: R2 R4 R5 R6 R7 R8 R9 R10
        for (int k = 0; k < 3000; k++) begin
            logic [5:0] a;
            a = ($urandom % 3 == 0) ? 6'h26 : ($urandom % 4 == 0) ? 6'($urandom) : 6'h00;
            bus($urandom % 3 == 0, a, 8'($urandom));
            bus_sel  = ($urandom % 4 != 0);
            pin_in   = 8'($urandom);
            ch1_mask = ($urandom % 2) ? 5'($urandom) : 5'd0;
            ch1_data = 5'($urandom);
            ded_en   = ($urandom % 2) ? 4'($urandom) : 4'd0;
            ded_val  = 4'($urandom);
            rst      = ($urandom % 500 == 0);
            cycle("random R5 R7 R9");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule